// File: doc/BRIEF.md
# Return stack with interrupt context

This block is the flow-control back end of a small 8-bit microcontroller core. Every clock it takes the address of the instruction now executing and resolved strobes from the decoder: call, return, interrupt return and the two interrupt-enable instructions. The condition of a conditional call or return is resolved outside and arrives as a single take/not-take bit. From these the block registers the next fetch address.

It keeps up to 30 return entries in a last-in first-out store. Each entry holds a 12-bit address together with the Z flag, the C flag and the register-bank select present when the entry was written. A call pushes the address that follows it. Taking the interrupt pushes the same thing and jumps to a fixed vector. The interrupt return pops an entry and hands the saved flags and bank select back to the core for one cycle.

A push into a full store does not wrap around. It raises a one-cycle internal reset request, empties the store and restarts fetch at address 0x000.

Top module: `ret_stack_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `next_pc` = 0x000, and `irq_ack`, `ie_out`, `core_rst`, `restore_valid` and all three restore bits at 0. The store is emptied.
- R2: With none of `ev_call`, `ev_ret` or `ev_reti` high and no interrupt taken, `next_pc` becomes `pc_in` + 1 modulo 4096 on the next edge.
- R3: A call with `cond_ok` = 1 sets `next_pc` to `jump_target` and pushes `pc_in` + 1. A return with `cond_ok` = 1 pops the newest entry into `next_pc`, so nested calls unwind in reverse order.
- R4: A call or return with `cond_ok` = 0 leaves the store unchanged and sets `next_pc` to `pc_in` + 1.
- R5: A push while 30 entries are held sets `core_rst` to 1 for exactly one cycle. It also sets `next_pc` to 0x000, clears `ie_out` and empties the store, and no `irq_ack` is raised.
- R6: A pop from an empty store gives `next_pc` = 0x000 and leaves the store empty.
- R7: The interrupt is taken in a cycle where `ie_out` = 1, `irq` = 1 and none of `ev_call`, `ev_ret`, `ev_reti` is high, even one whose `cond_ok` is 0. Taking it pushes `pc_in` + 1 with the current `flag_z`, `flag_c` and `bank_sel`. On the next edge `next_pc` becomes IRQ_VECTOR (default 0x3FF), `irq_ack` pulses for one cycle and `ie_out` becomes 0. With `ie_out` = 0 the `irq` input has no effect.
- R8: `ev_reti` acts whatever `cond_ok` is. It pops an entry into `next_pc` and sets `ie_out` to `reti_ie`. It raises `restore_valid` for one cycle with `restore_z`, `restore_c` and `restore_bank` equal to the popped entry's saved values, or 0 if the store was empty.
- R9: A plain return keeps `restore_valid` and the three restore bits at 0. The restore bits are 0 in every cycle where `restore_valid` is 0.
- R10: `ie_set` sets `ie_out` to 1 and `ie_clr` sets it to 0 on the next edge, unless an interrupt is taken or an overflow occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_in | input | 12 | Address of the instruction executing this cycle |
| jump_target | input | 12 | Destination of a call |
| cond_ok | input | 1 | Resolved condition for call or return (1 = take) |
| ev_call | input | 1 | Call instruction strobe |
| ev_ret | input | 1 | Return instruction strobe |
| ev_reti | input | 1 | Interrupt return strobe |
| reti_ie | input | 1 | Interrupt-enable value carried by the interrupt return |
| ie_set | input | 1 | Enable-interrupt instruction strobe |
| ie_clr | input | 1 | Disable-interrupt instruction strobe |
| irq | input | 1 | Interrupt request, held high by the source |
| flag_z | input | 1 | Current Z flag |
| flag_c | input | 1 | Current C flag |
| bank_sel | input | 1 | Current register-bank select |
| next_pc | output | 12 | Registered next fetch address |
| irq_ack | output | 1 | One-cycle pulse when the interrupt is taken |
| ie_out | output | 1 | Interrupt-enable state |
| core_rst | output | 1 | One-cycle internal reset request after a stack overflow |
| restore_valid | output | 1 | One-cycle pulse after an interrupt return |
| restore_z | output | 1 | Restored Z flag |
| restore_c | output | 1 | Restored C flag |
| restore_bank | output | 1 | Restored register-bank select |

## Verification
The bench fills the store to exactly 30 entries and then makes the 31st push. A design that wrapped instead would return to a stale address, and one that counted off by one would reset early or never. It pops from an empty store, both with a plain return and with an interrupt return. A design that underflowed the pointer would hand back a stale address and break the following call/return pair. It asserts `irq` while enable is off, while a call strobe with a true condition is present, and again inside the handler. A design that ignored the gating would take a nested or early interrupt, lose a call, or repeat `irq_ack`. A return made inside the handler must not restore context, while the following interrupt return must restore exactly the flags and bank saved at entry. A design that saved them in the wrong slot, or restored them on a plain return, would show the wrong bits on the restore outputs.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

  typedef struct packed {
    logic bank;
    logic c;
    logic z;
  } ctx_t;

  typedef enum logic [2:0] {
    ACT_SEQ,
    ACT_CALL,
    ACT_POP,
    ACT_IRQ,
    ACT_OVF
  } act_t;

endpackage

// File: rtl/rs_lifo.sv
module rs_lifo #(
  parameter int DEPTH = 30,
  parameter int DW    = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] sp;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  assign full  = (sp == PW'(DEPTH));
  assign empty = (sp == '0);

  // storage without reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[sp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)          sp <= '0;
    else if (push && !full)  sp <= sp + 1'b1;
    else if (pop && !empty)  sp <= sp - 1'b1;
  end

  assign rdata = empty ? '0 : mem[sp - 1'b1];

  assert_sp_bound_R5: assert property (@(posedge clk) disable iff (rst)
    sp <= PW'(DEPTH));

  assert_pop_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (sp == '0));

endmodule

// File: rtl/rs_irq_gate.sv
module rs_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic irq,
  input  logic flow_busy,
  input  logic ovf,
  input  logic reti,
  input  logic reti_ie,
  input  logic ie_set,
  input  logic ie_clr,
  output logic take,
  output logic ie
);
  logic ie_q;

  assign take = ie_q && irq && !flow_busy;
  assign ie   = ie_q;

  always_ff @(posedge clk) begin
    if (rst)              ie_q <= 1'b0;
    else if (ovf || take) ie_q <= 1'b0;
    else if (reti)        ie_q <= reti_ie;
    else if (ie_clr)      ie_q <= 1'b0;
    else if (ie_set)      ie_q <= 1'b1;
  end

  assert_take_clears_ie_R7: assert property (@(posedge clk) disable iff (rst)
    take |=> !ie_q);

  assert_reti_sets_ie_R8: assert property (@(posedge clk) disable iff (rst)
    (reti && !ovf) |=> (ie_q == $past(reti_ie)));

endmodule

// File: rtl/ret_stack_ctl.sv
module ret_stack_ctl
  import ret_stack_pkg::*;
#(
  parameter int             AW         = 12,
  parameter int             DEPTH      = 30,
  parameter logic [AW-1:0]  IRQ_VECTOR = 'h3FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] jump_target,
  input  logic          cond_ok,
  input  logic          ev_call,
  input  logic          ev_ret,
  input  logic          ev_reti,
  input  logic          reti_ie,
  input  logic          ie_set,
  input  logic          ie_clr,
  input  logic          irq,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic          bank_sel,
  output logic [AW-1:0] next_pc,
  output logic          irq_ack,
  output logic          ie_out,
  output logic          core_rst,
  output logic          restore_valid,
  output logic          restore_z,
  output logic          restore_c,
  output logic          restore_bank
);
  localparam int DW = AW + $bits(ctx_t);

  logic          busy, take, do_pop, do_push, ovf, full, empty;
  logic [AW-1:0] seq_pc;
  logic [DW-1:0] wdata, rdata;
  ctx_t          cur_ctx, pop_ctx, rctx_q;
  act_t          act;

  assign busy    = ev_call || ev_ret || ev_reti;
  assign seq_pc  = pc_in + 1'b1;
  assign do_pop  = ev_reti || (ev_ret && cond_ok);
  assign do_push = !do_pop && ((ev_call && cond_ok && !ev_ret && !ev_reti) || take);
  assign ovf     = do_push && full;
  assign cur_ctx = '{bank: bank_sel, c: flag_c, z: flag_z};
  assign wdata   = {cur_ctx, seq_pc};
  assign pop_ctx = ctx_t'(rdata[DW-1:AW]);

  always_comb begin
    if (ovf)           act = ACT_OVF;
    else if (do_pop)   act = ACT_POP;
    else if (take)     act = ACT_IRQ;
    else if (do_push)  act = ACT_CALL;
    else               act = ACT_SEQ;
  end

  rs_lifo #(.DEPTH(DEPTH), .DW(DW)) u_lifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (ovf),
    .push  (do_push),
    .pop   (do_pop),
    .wdata (wdata),
    .rdata (rdata),
    .full  (full),
    .empty (empty)
  );

  rs_irq_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .flow_busy (busy),
    .ovf       (ovf),
    .reti      (ev_reti),
    .reti_ie   (reti_ie),
    .ie_set    (ie_set),
    .ie_clr    (ie_clr),
    .take      (take),
    .ie        (ie_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc       <= '0;
      irq_ack       <= 1'b0;
      core_rst      <= 1'b0;
      restore_valid <= 1'b0;
      rctx_q        <= '0;
    end else begin
      irq_ack       <= (act == ACT_IRQ);
      core_rst      <= (act == ACT_OVF);
      restore_valid <= ev_reti;
      rctx_q        <= ev_reti ? pop_ctx : '0;
      case (act)
        ACT_OVF:  next_pc <= '0;
        ACT_POP:  next_pc <= rdata[AW-1:0];
        ACT_IRQ:  next_pc <= IRQ_VECTOR;
        ACT_CALL: next_pc <= jump_target;
        default:  next_pc <= seq_pc;
      endcase
    end
  end

  assign restore_z    = rctx_q.z;
  assign restore_c    = rctx_q.c;
  assign restore_bank = rctx_q.bank;

  assert_ack_vector_R7: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (next_pc == IRQ_VECTOR && !ie_out));

  assert_ovf_restart_R5: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> (next_pc == '0 && !ie_out && !irq_ack));

  assert_ovf_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> !core_rst);

  assert_restore_only_reti_R9: assert property (@(posedge clk) disable iff (rst)
    restore_valid |-> $past(ev_reti));

  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busy) && !irq_ack && !core_rst)
      |-> (next_pc == AW'($past(pc_in) + 1'b1)));

endmodule

// File: tb/ret_stack_ctl_bench.sv
module ret_stack_ctl_bench;
  localparam int DEPTH = 30;
  localparam logic [11:0] VEC = 12'h3FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] pc_in = '0, jump_target = '0;
  logic        cond_ok = 0, ev_call = 0, ev_ret = 0, ev_reti = 0, reti_ie = 0;
  logic        ie_set = 0, ie_clr = 0, irq = 0, flag_z = 0, flag_c = 0, bank_sel = 0;
  logic [11:0] next_pc;
  logic        irq_ack, ie_out, core_rst, restore_valid, restore_z, restore_c, restore_bank;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [18:0] exp_q[$];
  string       tag_q[$];

  logic [14:0] m_stk [DEPTH];
  int          m_sp = 0;
  bit          m_ie = 0;

  always #10 clk = ~clk;

  ret_stack_ctl u_ret_stack_ctl (
    .clk(clk), .rst(rst), .pc_in(pc_in), .jump_target(jump_target),
    .cond_ok(cond_ok), .ev_call(ev_call), .ev_ret(ev_ret), .ev_reti(ev_reti),
    .reti_ie(reti_ie), .ie_set(ie_set), .ie_clr(ie_clr), .irq(irq),
    .flag_z(flag_z), .flag_c(flag_c), .bank_sel(bank_sel),
    .next_pc(next_pc), .irq_ack(irq_ack), .ie_out(ie_out), .core_rst(core_rst),
    .restore_valid(restore_valid), .restore_z(restore_z), .restore_c(restore_c),
    .restore_bank(restore_bank)
  );

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input string tag, input logic r, input logic [11:0] pc,
                      input logic c_call, input logic c_ret, input logic c_reti,
                      input logic ok, input logic [11:0] tgt, input logic en,
                      input logic irq_i, input logic fz, input logic fc, input logic fb,
                      input logic s_set, input logic s_clr);
    logic [11:0] npc;
    logic        ack, crst, rv, rz, rc, rb, take;
    logic [14:0] e;
    @(negedge clk);
    rst = r; pc_in = pc; ev_call = c_call; ev_ret = c_ret; ev_reti = c_reti;
    cond_ok = ok; jump_target = tgt; reti_ie = en; irq = irq_i;
    flag_z = fz; flag_c = fc; bank_sel = fb; ie_set = s_set; ie_clr = s_clr;
    npc = pc + 12'd1; ack = 0; crst = 0; rv = 0; rz = 0; rc = 0; rb = 0;
    if (r) begin
      npc = 0; m_sp = 0; m_ie = 0;
    end else begin
      take = m_ie && irq_i && !(c_call || c_ret || c_reti);
      if (c_reti || (c_ret && ok)) begin
        if (m_sp > 0) begin m_sp--; e = m_stk[m_sp]; end
        else e = '0;
        npc = e[11:0];
        if (c_reti) begin rv = 1; rz = e[12]; rc = e[13]; rb = e[14]; end
      end else if ((c_call && ok) || take) begin
        if (m_sp == DEPTH) begin
          crst = 1; npc = 0; m_sp = 0;
        end else begin
          m_stk[m_sp] = {fb, fc, fz, pc + 12'd1};
          m_sp++;
          npc = take ? VEC : tgt;
          ack = take;
        end
      end
      if (crst || take) m_ie = 0;
      else if (c_reti)  m_ie = en;
      else if (s_clr)   m_ie = 0;
      else if (s_set)   m_ie = 1;
    end
    exp_q.push_back({crst, ack, m_ie, rv, rb, rc, rz, npc});
    tag_q.push_back(tag);
  endtask

  task automatic seq(input string tag, input logic [11:0] pc, input logic irq_i);
    step(tag, 0, pc, 0, 0, 0, 0, 12'h0, 0, irq_i, 0, 0, 0, 0, 0);
  endtask
  task automatic do_call(input string tag, input logic [11:0] pc, input logic [11:0] tgt,
                         input logic ok, input logic irq_i);
    step(tag, 0, pc, 1, 0, 0, ok, tgt, 0, irq_i, 0, 0, 0, 0, 0);
  endtask
  task automatic do_ret(input string tag, input logic [11:0] pc, input logic ok);
    step(tag, 0, pc, 0, 1, 0, ok, 12'h0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_reti(input string tag, input logic [11:0] pc, input logic en);
    step(tag, 0, pc, 0, 0, 1, 0, 12'h0, en, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic set_ie(input string tag, input logic [11:0] pc, input logic on);
    step(tag, 0, pc, 0, 0, 0, 0, 12'h0, 0, 0, 0, 0, 0, on, !on);
  endtask

  // monitor: compares outputs shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [18:0] got, expv;
      string t;
      expv = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {core_rst, irq_ack, ie_out, restore_valid, restore_bank, restore_c,
             restore_z, next_pc};
      checks++;
      if (got !== expv) begin
        errors++;
        $display("FAIL %s got %h exp %h (crst,ack,ie,rv,bank,c,z,pc)", t, got, expv);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step("R1", 1, 12'h123, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 12'h456, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0);
    seq("R2", 12'h005, 0);
    seq("R2", 12'hFFF, 0);
    do_ret("R6", 12'h010, 1);
    do_call("R3", 12'h020, 12'h100, 1, 0);
    do_call("R3", 12'h105, 12'h200, 1, 0);
    do_ret("R3", 12'h200, 1);
    do_call("R4", 12'h107, 12'h700, 0, 0);
    do_ret("R4", 12'h108, 0);
    do_ret("R3", 12'h109, 1);
    do_ret("R6", 12'h022, 1);
    seq("R7", 12'h030, 1);
    set_ie("R10", 12'h031, 1);
    do_call("R7", 12'h040, 12'h300, 1, 1);
    step("R7", 0, 12'h300, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 0);
    seq("R7", 12'h3FF, 1);
    do_call("R9", 12'h400, 12'h500, 1, 0);
    do_ret("R9", 12'h500, 1);
    do_reti("R8", 12'h401, 1);
    do_ret("R3", 12'h301, 1);
    do_reti("R8", 12'h050, 0);
    set_ie("R10", 12'h060, 1);
    set_ie("R10", 12'h061, 0);
    set_ie("R5", 12'h062, 1);
    for (int i = 0; i < DEPTH; i++) do_call("R5", 12'(i), 12'(12'h600 + i), 1, 0);
    do_call("R5", 12'h0AA, 12'h7AA, 1, 0);
    do_ret("R5", 12'h000, 1);
    do_call("R3", 12'h080, 12'h090, 1, 0);
    do_ret("R3", 12'h090, 1);
    step("R1", 1, 12'h777, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    seq("R2", 12'h001, 0);
    @(negedge clk);
    rst = 0; ev_call = 0; ev_ret = 0; ev_reti = 0; irq = 0; ie_set = 0; ie_clr = 0;
    while (exp_q.size() > 0) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule